// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a bank of SDRAM from power-on to normal operation without software help. After reset it waits for supply and clock settling, then walks a fixed list of memory commands: a no-operation, a precharge of all banks, a burst of auto-refresh cycles, a load of the mode register and finally the switch to normal operation. Each command is handed to a downstream command broadcaster over a request/done handshake, and a programmable pause, counted in microseconds, follows each one.

Time is measured with a single microsecond tick pulse supplied from outside, so the sequencer needs no knowledge of the system clock frequency. Once the last pause has elapsed the block raises its initialization-complete and refresh-enable outputs together and then goes silent until the next reset. Every pause, the refresh count, the mode-register address and the port widths are parameters.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n (active low, asynchronous) is asserted, cmd_req, init_done and refresh_en are all 0.
- R2: The first cmd_req rises only after STARTUP_US (default 200) us_tick pulses have been sampled since reset was released.
- R3: Commands are issued in this order, with these cmd_code values: no-operation 3'd1, precharge-all 3'd2, auto-refresh 3'd6 repeated exactly REFRESH_COUNT (default 8) times, mode-register load 3'd3, normal operation 3'd7.
- R4: cmd_addr equals MODE_OFFSET (default 12'h1D0) while the mode-register load is requested and is zero for every other command.
- R5: A command is accepted on a clock edge where cmd_req and cmd_done are both 1. Until then cmd_req stays high with cmd_code and cmd_addr unchanged; one cycle after acceptance cmd_req is 0.
- R6: After each accepted command the next request (or completion) follows only after a fixed count of us_tick pulses sampled after the accepting edge: 200 after no-operation, 1 after precharge-all, 1 after each auto-refresh, 2 after the mode-register load, 1 after normal operation.
- R7: cmd_done sampled while cmd_req is 0 has no effect on the sequence or on any wait.
- R8: init_done and refresh_en rise together, in the cycle after the wait that follows the normal-operation command runs out, and never before that command is accepted.
- R9: After completion init_done and refresh_en stay 1 and cmd_req stays 0 until the next reset.
- R10: A reset applied in the middle of the sequence abandons it; after release the whole sequence starts again from the startup wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cmd_done | input | 1 | Broadcaster has finished the requested command |
| cmd_code | output | 3 | Memory command to broadcast |
| cmd_addr | output | ADDR_W (12) | Address offset sent with the command |
| cmd_req | output | 1 | Command request, held until cmd_done |
| init_done | output | 1 | Initialization complete |
| refresh_en | output | 1 | Periodic refresh may run |

## Verification
The hardest situations to reach from the ports are a reset that lands in the middle of the refresh burst and a stray done pulse that arrives while a wait is running. The bench walks a table of the twelve expected commands with their codes, addresses and following pauses, then reruns the sequence with a slow responder, and finally cuts one run short with reset after the fifth command and checks that the restart begins again with the startup wait. Stray done pulses are injected during the startup and no-operation waits and must leave the measured tick counts unchanged.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

   // Command codes decoded by the downstream broadcaster
   typedef enum logic [2:0] {
      CMD_NOP           = 3'd1,
      CMD_PRECHARGE_ALL = 3'd2,
      CMD_MODE_SET      = 3'd3,
      CMD_AUTO_REFRESH  = 3'd6,
      CMD_NORMAL        = 3'd7
   } sdram_cmd_e;

   // Steps of the power-up walk, in issue order
   typedef enum logic [2:0] {
      PH_NOP       = 3'd0,
      PH_PRECHARGE = 3'd1,
      PH_REFRESH   = 3'd2,
      PH_MODE_SET  = 3'd3,
      PH_NORMAL    = 3'd4,
      PH_FINISHED  = 3'd5
   } init_phase_e;

   typedef enum logic [1:0] {
      SQ_WAIT  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_DONE  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/pwrup_us_timer.sv
module pwrup_us_timer #(
   parameter int W         = 9,
   parameter int RESET_VAL = 200,
   parameter bit TICK_REG  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_in,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   localparam logic [W-1:0] RST_CNT = W'(RESET_VAL);

   if (W < 1) begin : g_bad_width
      $error("pwrup_us_timer: W must be at least 1");
   end
   if (RESET_VAL >= (1 << W)) begin : g_bad_reset
      $error("pwrup_us_timer: RESET_VAL does not fit in W bits");
   end

   logic         tick_use;
   logic [W-1:0] count_q;

   // Optional retiming flop on the tick for long routes
   if (TICK_REG) begin : g_tick_flop
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= tick_in;
      end
      assign tick_use = tick_q;
   end else begin : g_tick_direct
      assign tick_use = tick_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= RST_CNT;
      end else if (load) begin
         count_q <= load_val;
      end else if (tick_use && (count_q != '0)) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign expired = (count_q == '0);

endmodule

// File: rtl/pwrup_rep_cnt.sv
module pwrup_rep_cnt #(
   parameter int COUNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bump,
   output logic last
);

   if (COUNT < 1) begin : g_bad_count
      $error("pwrup_rep_cnt: COUNT must be at least 1");
   end

   if (COUNT == 1) begin : g_single
      logic unused_pins;
      assign unused_pins = &{1'b0, clk, rst_n, bump};
      assign last = 1'b1;
   end else begin : g_multi
      localparam int CW = $clog2(COUNT);
      localparam logic [CW-1:0] LAST_VAL = CW'(COUNT - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (bump) begin
            if (cnt_q == LAST_VAL) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
      end

      assign last = (cnt_q == LAST_VAL);
   end

endmodule

// File: rtl/pwrup_step_decode.sv
module pwrup_step_decode
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W            = 12,
   parameter int WAIT_W            = 9,
   parameter int MODE_OFFSET       = 'h1D0,
   parameter int NOP_WAIT_US       = 200,
   parameter int PRECHARGE_WAIT_US = 1,
   parameter int REFRESH_WAIT_US   = 1,
   parameter int MODE_WAIT_US      = 2,
   parameter int NORMAL_WAIT_US    = 1
) (
   input  init_phase_e        phase,
   output sdram_cmd_e         cmd,
   output logic [ADDR_W-1:0]  addr,
   output logic [WAIT_W-1:0]  delay
);

   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_OFFSET);
   localparam logic [WAIT_W-1:0] D_NOP     = WAIT_W'(NOP_WAIT_US);
   localparam logic [WAIT_W-1:0] D_PRE     = WAIT_W'(PRECHARGE_WAIT_US);
   localparam logic [WAIT_W-1:0] D_REF     = WAIT_W'(REFRESH_WAIT_US);
   localparam logic [WAIT_W-1:0] D_MODE    = WAIT_W'(MODE_WAIT_US);
   localparam logic [WAIT_W-1:0] D_NORM    = WAIT_W'(NORMAL_WAIT_US);

   always_comb begin
      cmd   = CMD_NOP;
      addr  = '0;
      delay = '0;
      case (phase)
         PH_NOP: begin
            cmd   = CMD_NOP;
            delay = D_NOP;
         end
         PH_PRECHARGE: begin
            cmd   = CMD_PRECHARGE_ALL;
            delay = D_PRE;
         end
         PH_REFRESH: begin
            cmd   = CMD_AUTO_REFRESH;
            delay = D_REF;
         end
         PH_MODE_SET: begin
            cmd   = CMD_MODE_SET;
            addr  = MODE_ADDR;
            delay = D_MODE;
         end
         PH_NORMAL: begin
            cmd   = CMD_NORMAL;
            delay = D_NORM;
         end
         default: begin
            cmd   = CMD_NOP;
         end
      endcase
   end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W            = 12,
   parameter int WAIT_W            = 9,
   parameter int STARTUP_US        = 200,
   parameter int NOP_WAIT_US       = 200,
   parameter int PRECHARGE_WAIT_US = 1,
   parameter int REFRESH_COUNT     = 8,
   parameter int REFRESH_WAIT_US   = 1,
   parameter int MODE_WAIT_US      = 2,
   parameter int NORMAL_WAIT_US    = 1,
   parameter int MODE_OFFSET       = 'h1D0,
   parameter bit TICK_REG          = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              cmd_done,
   output logic [2:0]        cmd_code,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_req,
   output logic              init_done,
   output logic              refresh_en
);

   localparam int WAIT_LIMIT = 1 << WAIT_W;

   if (STARTUP_US >= WAIT_LIMIT || NOP_WAIT_US >= WAIT_LIMIT ||
       PRECHARGE_WAIT_US >= WAIT_LIMIT || REFRESH_WAIT_US >= WAIT_LIMIT ||
       MODE_WAIT_US >= WAIT_LIMIT || NORMAL_WAIT_US >= WAIT_LIMIT) begin : g_bad_wait
      $error("sdram_pwrup_seq: a wait does not fit in WAIT_W bits");
   end
   if (MODE_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
      $error("sdram_pwrup_seq: MODE_OFFSET does not fit in ADDR_W bits");
   end
   if (REFRESH_COUNT < 1) begin : g_bad_refresh
      $error("sdram_pwrup_seq: REFRESH_COUNT must be at least 1");
   end

   seq_state_e        state_q;
   init_phase_e       phase_q;
   init_phase_e       phase_next;
   sdram_cmd_e        dec_cmd;
   logic [ADDR_W-1:0] dec_addr;
   logic [WAIT_W-1:0] dec_delay;
   logic              accept;
   logic              wait_over;
   logic              rep_last;

   assign accept = (state_q == SQ_ISSUE) && cmd_done;

   pwrup_step_decode #(
      .ADDR_W            (ADDR_W),
      .WAIT_W            (WAIT_W),
      .MODE_OFFSET       (MODE_OFFSET),
      .NOP_WAIT_US       (NOP_WAIT_US),
      .PRECHARGE_WAIT_US (PRECHARGE_WAIT_US),
      .REFRESH_WAIT_US   (REFRESH_WAIT_US),
      .MODE_WAIT_US      (MODE_WAIT_US),
      .NORMAL_WAIT_US    (NORMAL_WAIT_US)
   ) u_decode (
      .phase (phase_q),
      .cmd   (dec_cmd),
      .addr  (dec_addr),
      .delay (dec_delay)
   );

   pwrup_us_timer #(
      .W         (WAIT_W),
      .RESET_VAL (STARTUP_US),
      .TICK_REG  (TICK_REG)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (us_tick),
      .load     (accept),
      .load_val (dec_delay),
      .expired  (wait_over)
   );

   pwrup_rep_cnt #(
      .COUNT (REFRESH_COUNT)
   ) u_refresh_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (accept && (phase_q == PH_REFRESH)),
      .last  (rep_last)
   );

   // Stay on the refresh step until its last repetition is accepted
   always_comb begin
      if ((phase_q == PH_REFRESH) && !rep_last) phase_next = phase_q;
      else                                      phase_next = init_phase_e'(phase_q + 3'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_WAIT;
         phase_q <= PH_NOP;
      end else begin
         case (state_q)
            SQ_WAIT: begin
               if (wait_over) begin
                  state_q <= (phase_q == PH_FINISHED) ? SQ_DONE : SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               if (cmd_done) begin
                  state_q <= SQ_WAIT;
                  phase_q <= phase_next;
               end
            end
            SQ_DONE: begin
               state_q <= SQ_DONE;
            end
            default: begin
               state_q <= SQ_WAIT;
            end
         endcase
      end
   end

   assign cmd_req    = (state_q == SQ_ISSUE);
   assign cmd_code   = dec_cmd;
   assign cmd_addr   = dec_addr;
   assign init_done  = (state_q == SQ_DONE);
   assign refresh_en = (state_q == SQ_DONE);

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
   parameter int ADDR_W        = 12,
   parameter int MODE_OFFSET   = 'h1D0,
   parameter int REFRESH_COUNT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_done,
   input logic [2:0]        cmd_code,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              cmd_req,
   input logic              init_done,
   input logic              refresh_en
);

   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_OFFSET);
   localparam int CW = $clog2(REFRESH_COUNT + 2) + 1;
   localparam logic [CW-1:0] REF_TARGET = CW'(REFRESH_COUNT);

   logic [CW-1:0] refresh_seen_q;
   logic          normal_seen_q;
   logic          taken;

   assign taken = cmd_req && cmd_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         refresh_seen_q <= '0;
         normal_seen_q  <= 1'b0;
      end else if (taken) begin
         if (cmd_code == 3'd6 && refresh_seen_q != '1) refresh_seen_q <= refresh_seen_q + 1'b1;
         if (cmd_code == 3'd7) normal_seen_q <= 1'b1;
      end
   end

   // R5: request held steady until done
   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_code) && $stable(cmd_addr)));

   // R5: request withdrawn after acceptance
   p_req_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> !cmd_req);

   // R4: mode-register load carries the offset, others carry zero
   p_mode_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_code == 3'd3) |-> (cmd_addr == MODE_ADDR));

   p_plain_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_code != 3'd3) |-> (cmd_addr == '0));

   // R3: only defined command codes, and the full refresh burst before the mode load
   p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (cmd_code == 3'd1 || cmd_code == 3'd2 || cmd_code == 3'd3 ||
                   cmd_code == 3'd6 || cmd_code == 3'd7));

   p_refresh_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && cmd_code == 3'd3) |-> (refresh_seen_q == REF_TARGET));

   // R8: completion only after normal operation accepted
   p_done_after_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (normal_seen_q && refresh_en));

   // R9: completion is sticky and silent
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> (init_done && refresh_en));

   p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> !cmd_req);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
   .ADDR_W        (ADDR_W),
   .MODE_OFFSET   (MODE_OFFSET),
   .REFRESH_COUNT (REFRESH_COUNT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_done   (cmd_done),
   .cmd_code   (cmd_code),
   .cmd_addr   (cmd_addr),
   .cmd_req    (cmd_req),
   .init_done  (init_done),
   .refresh_en (refresh_en)
);

// File: tb/sdram_pwrup_seq_test.sv
module sdram_pwrup_seq_test;

   localparam int TICK_DIV   = 5;
   localparam int NSEQ       = 12;
   localparam int STARTUP    = 200;
   localparam int WATCH_CYC  = 200000;

   // {code[2:0], addr[11:0], following wait[8:0]}
   localparam logic [23:0] SEQ_TBL [NSEQ] = '{
      {3'd1, 12'h000, 9'd200},
      {3'd2, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd6, 12'h000, 9'd1},
      {3'd3, 12'h1D0, 9'd2},
      {3'd7, 12'h000, 9'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        us_tick = 1'b0;
   logic        rsp_done = 1'b0;
   logic        spur_done = 1'b0;
   logic        cmd_done;
   logic [2:0]  cmd_code;
   logic [11:0] cmd_addr;
   logic        cmd_req;
   logic        init_done;
   logic        refresh_en;

   assign cmd_done = rsp_done | spur_done;

   always #5 clk = ~clk;

   sdram_pwrup_seq uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .us_tick    (us_tick),
      .cmd_done   (cmd_done),
      .cmd_code   (cmd_code),
      .cmd_addr   (cmd_addr),
      .cmd_req    (cmd_req),
      .init_done  (init_done),
      .refresh_en (refresh_en)
   );

   int nchk = 0;
   int nfail = 0;
   int tcnt = 0;
   int latency = 0;
   int lat_cnt = 0;
   int spur_a = 0;
   int spur_b = 0;
   bit finished = 1'b0;

   // monitor state
   logic        prev_req, prev_tick, prev_done, prev_init;
   logic [2:0]  prev_code;
   logic [11:0] prev_addr;
   int          idx;
   int          ticks;
   bit          counting;
   int          exp_delay;
   bit          seq_complete;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive_inputs();
      prev_req  = cmd_req;
      prev_code = cmd_code;
      prev_addr = cmd_addr;
      prev_init = init_done;
      if (rst_n) tcnt++;
      else       tcnt = 0;
      us_tick = rst_n && (tcnt > 0) && (tcnt % TICK_DIV == 0);
      if (rsp_done) begin
         rsp_done = 1'b0;
      end else if (cmd_req) begin
         if (lat_cnt >= latency) begin
            rsp_done = 1'b1;
            lat_cnt  = 0;
         end else begin
            lat_cnt++;
         end
      end else begin
         lat_cnt = 0;
      end
      spur_done = !cmd_req && ((spur_a > 0 && tcnt == spur_a) || (spur_b > 0 && tcnt == spur_b));
      prev_tick = us_tick;
      prev_done = rsp_done | spur_done;
   endtask

   task automatic step();
      @(negedge clk);
      if (prev_req && prev_done) begin
         check(!cmd_req, "R5 request drops after accept", int'(cmd_req), 0);
         counting = 1'b1;
         ticks    = 0;
      end else begin
         if (counting && prev_tick) ticks++;
         if (prev_req) begin
            check(cmd_req && cmd_code == prev_code && cmd_addr == prev_addr,
                  "R5 request held steady", int'(cmd_code), int'(prev_code));
         end
      end
      if (cmd_req && !prev_req) begin
         check(ticks == exp_delay, (idx == 0) ? "R2 R7 startup wait" : "R6 R7 wait after command",
               ticks, exp_delay);
         if (idx < NSEQ) begin
            check(cmd_code == SEQ_TBL[idx][23:21], "R3 command order", int'(cmd_code),
                  int'(SEQ_TBL[idx][23:21]));
            check(cmd_addr == SEQ_TBL[idx][20:9], "R4 command address", int'(cmd_addr),
                  int'(SEQ_TBL[idx][20:9]));
            exp_delay = int'(SEQ_TBL[idx][8:0]);
         end else begin
            check(1'b0, "R9 extra command after sequence", idx, NSEQ);
         end
         idx++;
         counting = 1'b0;
      end
      if (init_done && !prev_init) begin
         check(idx == NSEQ, "R3 command count before completion", idx, NSEQ);
         check(ticks == exp_delay, "R6 wait after normal operation", ticks, exp_delay);
         check(refresh_en, "R8 refresh enabled with completion", int'(refresh_en), 1);
         seq_complete = 1'b1;
      end
      drive_inputs();
   endtask

   task automatic apply_reset(input string tag);
      @(negedge clk);
      rst_n     = 1'b0;
      us_tick   = 1'b0;
      rsp_done  = 1'b0;
      spur_done = 1'b0;
      repeat (3) @(negedge clk);
      check(!cmd_req, {tag, " cmd_req low in reset"}, int'(cmd_req), 0);
      check(!init_done, {tag, " init_done low in reset"}, int'(init_done), 0);
      check(!refresh_en, {tag, " refresh_en low in reset"}, int'(refresh_en), 0);
      rst_n        = 1'b1;
      tcnt         = 0;
      lat_cnt      = 0;
      idx          = 0;
      ticks        = 0;
      counting     = 1'b1;
      exp_delay    = STARTUP;
      seq_complete = 1'b0;
      prev_req     = 1'b0;
      prev_tick    = 1'b0;
      prev_done    = 1'b0;
      prev_init    = 1'b0;
      prev_code    = '0;
      prev_addr    = '0;
   endtask

   task automatic run_seq(input int max_cyc, input int stop_idx);
      for (int k = 0; k < max_cyc; k++) begin
         step();
         if (seq_complete) break;
         if (stop_idx > 0 && idx >= stop_idx) break;
      end
   endtask

   initial begin
      // Run 1: immediate responder, stray done pulses during two long waits
      latency = 0;
      spur_a  = 50;
      spur_b  = 1100;
      apply_reset("R1");
      run_seq(6000, 0);
      check(seq_complete, "R8 first sequence completes", int'(seq_complete), 1);

      // Completion is sticky and silent
      begin
         int bad = 0;
         for (int k = 0; k < 300; k++) begin
            step();
            if (cmd_req || !init_done || !refresh_en) bad++;
         end
         check(bad == 0, "R9 outputs stay after completion", bad, 0);
      end

      // Run 2: slow responder exercises request holding
      latency = 4;
      spur_a  = 0;
      spur_b  = 0;
      apply_reset("R1");
      run_seq(8000, 0);
      check(seq_complete, "R5 sequence completes with slow responder", int'(seq_complete), 1);

      // Run 3: reset in the middle of the refresh burst, then a full restart
      latency = 1;
      apply_reset("R1");
      run_seq(8000, 5);
      check(idx == 5 && !init_done, "R10 reached mid-sequence", idx, 5);
      repeat (3) step();
      apply_reset("R10");
      run_seq(8000, 0);
      check(seq_complete, "R10 restarted sequence completes", int'(seq_complete), 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(WATCH_CYC * 10);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCH_CYC, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule